// File: doc/BRIEF.md
# Page Buffer with Timed Write Commit

This block sits behind a serial-memory protocol engine and turns a stream of received data bytes into page-sized updates of a small byte array. Each accepted byte lands in a page-wide staging latch at the slot given by the low address bits. Every slot has its own valid flag. The page row, taken from the upper address bits, is captured from the first byte of a transaction and stays fixed after that. When the transaction ends with a stop and at least one byte is staged, the block commits the staged bytes. Only slots that were written are copied into the array, and each such slot lands at its column of the captured row. The block then holds a busy flag for a programmable number of clock ticks, which stands in for the self-timed program cycle.

A write-protect input is sampled at the stop. When it is high, the staged bytes are dropped, the array is left as it was and busy is not raised. A start or abort that comes before the stop throws away the staged bytes. A stop that has no staged byte in front of it starts no cycle. This is the case for the address-only dummy write that comes before a random read. While busy is high the block takes no access of any kind.

Both data paths are valid/ready. A write byte transfers in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while busy and in any cycle that carries a start, stop or abort pulse. A read request transfers when `rd_valid` and `rd_ready` are both high, and `rd_ready` equals not-busy. Every accepted read returns exactly one cycle later on `rd_rsp_valid`/`rd_rsp_data`. The response path has no back-pressure. The array holds `MEM_BYTES` bytes and is addressed modulo its size.

Top module: `pbw_page_writer`

## Requirements
- R1: After reset `busy` is low and every array byte reads as the erased value 0xFF.
- R2: A byte whose address has column c = addr[5:0] goes to slot c. The row addr[14:6] is taken only from the first byte accepted in a transaction. The upper bits of later bytes are ignored.
- R3: `busy` rises in the cycle after a stop, and only when at least one byte is staged and `wprot` is low. A stop with no staged byte leaves `busy` low. This includes a stop right after a completed commit.
- R4: Once raised, `busy` stays high for exactly `WR_TICKS` cycles.
- R5: While `busy` is high, `wr_ready` and `rd_ready` are low. Any write, read, start, stop or abort presented during that time has no effect.
- R6: A stop with `wprot` high changes no array byte, does not raise `busy`, and drops the staged bytes.
- R7: A commit changes only the array bytes whose slots were written. Every other byte keeps its value. Array writes happen only while `busy` is high.
- R8: When a transaction writes the same column more than once, for example when more than 64 bytes are sent, the last byte written to that column wins.
- R9: A start or abort before the stop drops all staged bytes, so that a following stop commits nothing.
- R10: An accepted read of `rd_addr` returns the byte at index rd_addr mod `MEM_BYTES` on `rd_rsp_data`, with `rd_rsp_valid` high, one cycle later. No other cycle has `rd_rsp_valid` high.
- R11: `wr_ready` is low in any cycle where `txn_start`, `txn_stop` or `txn_abort` is high. A byte offered in that cycle is not staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken |
| wr_addr | input | 15 | Byte address (row and column) |
| wr_data | input | 8 | Byte value |
| txn_start | input | 1 | Start-condition pulse |
| txn_stop | input | 1 | Stop-condition pulse |
| txn_abort | input | 1 | Protocol abort pulse |
| wprot | input | 1 | Write protect, sampled at stop |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request can be taken |
| rd_addr | input | 15 | Read byte address |
| rd_rsp_valid | output | 1 | Read data valid (one cycle after request) |
| rd_rsp_data | output | 8 | Read data |
| busy | output | 1 | Timed commit in progress |

## Verification
The commit path is exercised with several write patterns:
- a single isolated byte, which shows that only written slots are copied and that neighbours keep their value;
- a 68-byte burst whose later bytes carry a different row, which checks both column wrap-around with last-write-wins and that the row is fixed by the first byte;
- a stop with write protect high, which must leave the array untouched and busy low;
- transactions cut short by a restart, by an abort, or by a stop with no staged byte, none of which may start a cycle.

Accesses offered inside the busy window, and a byte offered in the same cycle as a stop, show that the window and the control pulses really block traffic. A read beyond the array size checks the address wrap.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_PROG = 1'b1
  } prog_state_e;

endpackage

// File: rtl/pbw_page_latch.sv
module pbw_page_latch #(
  parameter int PAGE_BYTES = 64,
  parameter int ROW_W      = 9,
  parameter int DATA_W     = 8,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put,
  input  logic [COL_W-1:0]  put_col,
  input  logic [ROW_W-1:0]  put_row,
  input  logic [DATA_W-1:0] put_data,
  input  logic              clear,
  input  logic [COL_W-1:0]  sel_col,
  output logic [ROW_W-1:0]  row,
  output logic              any_valid,
  output logic              sel_valid,
  output logic [DATA_W-1:0] sel_data
);

  logic [PAGE_BYTES-1:0] vld_q;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [ROW_W-1:0]      row_q;

  // valid flags and row capture
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      row_q <= '0;
    end else if (clear) begin
      vld_q <= '0;
    end else if (put) begin
      vld_q[put_col] <= 1'b1;
      if (vld_q == '0) row_q <= put_row;
    end
  end

  // one storage register per slot
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (put && !clear && (put_col == COL_W'(g))) slot_q[g] <= put_data;
    end
  end

  assign row       = row_q;
  assign any_valid = |vld_q;
  assign sel_valid = vld_q[sel_col];
  assign sel_data  = slot_q[sel_col];

endmodule

// File: rtl/pbw_commit_timer.sv
module pbw_commit_timer
  import pbw_pkg::*;
#(
  parameter int WR_TICKS   = 80,
  parameter int PAGE_BYTES = 64,
  localparam int CNT_W     = $clog2(WR_TICKS + 1),
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  output logic             busy,
  output logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  prog_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == CNT_W'(WR_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PS_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PS_IDLE: begin
          cnt_q <= '0;
          if (launch) st_q <= PS_PROG;
        end
        PS_PROG: begin
          if (last) begin
            st_q  <= PS_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  assign busy = (st_q == PS_PROG);
  assign step = busy && (cnt_q < CNT_W'(PAGE_BYTES));
  assign idx  = cnt_q[IDX_W-1:0];
  assign done = busy && last;

endmodule

// File: rtl/pbw_byte_array.sv
module pbw_byte_array #(
  parameter int          MEM_BYTES = 1024,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  ERASED    = 8'hFF,
  localparam int         MEM_AW    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [MEM_AW-1:0] raddr,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= DATA_W'(ERASED);
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= re;
      if (re) rdata <= mem_q[raddr];
    end
  end

endmodule

// File: rtl/pbw_page_writer.sv
module pbw_page_writer #(
  parameter int         ADDR_W     = 15,
  parameter int         DATA_W     = 8,
  parameter int         PAGE_BYTES = 64,
  parameter int         MEM_BYTES  = 1024,
  parameter int         WR_TICKS   = 80,
  parameter logic [7:0] ERASED     = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              txn_start,
  input  logic              txn_stop,
  input  logic              txn_abort,
  input  logic              wprot,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_rsp_valid,
  output logic [DATA_W-1:0] rd_rsp_data,
  output logic              busy
);

  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int MEM_AW = $clog2(MEM_BYTES);

  logic              ctrl_evt;
  logic              put;
  logic              launch;
  logic              clear;
  logic              done;
  logic              step;
  logic [COL_W-1:0]  idx;
  logic [ROW_W-1:0]  row;
  logic              any_valid;
  logic              sel_valid;
  logic [DATA_W-1:0] sel_data;
  logic              arr_we;
  logic [ADDR_W-1:0] waddr_full;
  logic [MEM_AW-1:0] arr_waddr;
  logic [MEM_AW-1:0] arr_raddr;

  assign ctrl_evt = txn_start | txn_stop | txn_abort;
  assign wr_ready = !busy && !ctrl_evt;
  assign rd_ready = !busy;
  assign put      = wr_valid && wr_ready;
  assign launch   = !busy && txn_stop && any_valid && !wprot;
  assign clear    = (!busy && ctrl_evt && !launch) || done;

  pbw_page_latch #(
    .PAGE_BYTES (PAGE_BYTES),
    .ROW_W      (ROW_W),
    .DATA_W     (DATA_W)
  ) u_latch (
    .clk       (clk),
    .rst       (rst),
    .put       (put),
    .put_col   (wr_addr[COL_W-1:0]),
    .put_row   (wr_addr[ADDR_W-1:COL_W]),
    .put_data  (wr_data),
    .clear     (clear),
    .sel_col   (idx),
    .row       (row),
    .any_valid (any_valid),
    .sel_valid (sel_valid),
    .sel_data  (sel_data)
  );

  pbw_commit_timer #(
    .WR_TICKS   (WR_TICKS),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .busy   (busy),
    .step   (step),
    .idx    (idx),
    .done   (done)
  );

  assign arr_we     = step && sel_valid;
  assign waddr_full = {row, idx};
  assign arr_waddr  = MEM_AW'(waddr_full % MEM_BYTES);
  assign arr_raddr  = MEM_AW'(rd_addr % MEM_BYTES);

  pbw_byte_array #(
    .MEM_BYTES (MEM_BYTES),
    .DATA_W    (DATA_W),
    .ERASED    (ERASED)
  ) u_array (
    .clk    (clk),
    .rst    (rst),
    .we     (arr_we),
    .waddr  (arr_waddr),
    .wdata  (sel_data),
    .re     (rd_valid && rd_ready),
    .raddr  (arr_raddr),
    .rvalid (rd_rsp_valid),
    .rdata  (rd_rsp_data)
  );

endmodule

// File: rtl/pbw_page_writer_chk.sv
module pbw_page_writer_chk #(
  parameter int WR_TICKS = 80
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic wr_ready,
  input logic rd_ready,
  input logic txn_stop,
  input logic wprot,
  input logic arr_we
);

  logic [31:0] blen_q;

  always_ff @(posedge clk) begin
    if (rst || !busy) blen_q <= '0;
    else              blen_q <= blen_q + 1;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(blen_q) == 32'(WR_TICKS - 1));  // R4

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> blen_q < 32'(WR_TICKS));  // R4

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!wr_ready && !rd_ready));  // R5

  AST_WP_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (txn_stop && wprot && !busy) |=> !busy);  // R6

  AST_LAUNCH_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(txn_stop));  // R3

  AST_WRITE_INSIDE: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);  // R7

endmodule

bind pbw_page_writer pbw_page_writer_chk #(.WR_TICKS(WR_TICKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .wr_ready (wr_ready),
  .rd_ready (rd_ready),
  .txn_stop (txn_stop),
  .wprot    (wprot),
  .arr_we   (arr_we)
);

// File: tb/test_pbw_page_writer.sv
`timescale 1ns/1ps
module test_pbw_page_writer;

  localparam int MEM_BYTES = 1024;
  localparam int WR_TICKS  = 80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 0, txn_start = 0, txn_stop = 0, txn_abort = 0;
  logic        wprot = 0, rd_valid = 0;
  logic [14:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready, rd_ready, rd_rsp_valid, busy;
  logic [7:0]  rd_rsp_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pbw_page_writer #(.MEM_BYTES(MEM_BYTES), .WR_TICKS(WR_TICKS)) i_pbw_page_writer (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .txn_start(txn_start), .txn_stop(txn_stop), .txn_abort(txn_abort), .wprot(wprot),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .busy(busy)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] ref_mem [MEM_BYTES];
  bit         bv [64];
  logic [7:0] bd [64];
  int         brow, bcnt, m_left;
  bit         m_busy, m_rsp_v;
  logic [7:0] m_rsp_d;

  function automatic void drop_buf();
    bcnt = 0;
    for (int c = 0; c < 64; c++) bv[c] = 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_left = 0; m_rsp_v = 0; m_rsp_d = '0; brow = 0;
      for (int i = 0; i < MEM_BYTES; i++) ref_mem[i] = 8'hFF;
      drop_buf();
    end else begin
      m_rsp_v = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) m_busy = 0;
      end else begin
        if (rd_valid) begin
          m_rsp_v = 1;
          m_rsp_d = ref_mem[int'(rd_addr) % MEM_BYTES];
        end
        if (txn_stop) begin
          if (bcnt > 0 && !wprot) begin
            for (int c = 0; c < 64; c++)
              if (bv[c]) ref_mem[(brow * 64 + c) % MEM_BYTES] = bd[c];
            m_busy = 1;
            m_left = WR_TICKS;
          end
          drop_buf();
        end else if (txn_start || txn_abort) begin
          drop_buf();
        end else if (wr_valid) begin
          if (bcnt == 0) brow = int'(wr_addr) / 64;
          bv[int'(wr_addr) % 64] = 1;
          bd[int'(wr_addr) % 64] = wr_data;
          bcnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 busy vs model", {31'b0, busy}, {31'b0, m_busy});
      chk("R5 rd_ready vs model", {31'b0, rd_ready}, {31'b0, !m_busy});
      chk("R11 wr_ready vs model", {31'b0, wr_ready},
          {31'b0, !m_busy && !(txn_start || txn_stop || txn_abort)});
      chk("R10 rsp_valid vs model", {31'b0, rd_rsp_valid}, {31'b0, m_rsp_v});
      if (m_rsp_v) chk("R10 rsp_data vs model", {24'b0, rd_rsp_data}, {24'b0, m_rsp_d});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put_byte(input int addr, input int data);
    wr_valid = 1; wr_addr = 15'(addr); wr_data = 8'(data);
    tick();
    wr_valid = 0;
  endtask

  task automatic pulse_start(); txn_start = 1; tick(); txn_start = 0; endtask
  task automatic pulse_stop();  txn_stop  = 1; tick(); txn_stop  = 0; endtask
  task automatic pulse_abort(); txn_abort = 1; tick(); txn_abort = 0; endtask

  task automatic wait_idle();
    while (busy) tick();
  endtask

  task automatic read_chk(string tag, input int addr, input int exp);
    rd_valid = 1; rd_addr = 15'(addr);
    tick();
    rd_valid = 0;
    chk({tag, " rsp_valid"}, {31'b0, rd_rsp_valid}, 32'd1);
    chk({tag, " data"}, {24'b0, rd_rsp_data}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (4) tick();
    rst = 0;
    tick();

    // R1 reset state
    chk("R1 busy after reset", {31'b0, busy}, 32'd0);
    read_chk("R1 erased low", 0, 8'hFF);
    read_chk("R1 erased high", MEM_BYTES - 1, 8'hFF);

    // single byte, partial page
    pulse_start();
    put_byte(15'h105, 8'hA5);
    pulse_stop();
    chk("R3 busy after stop", {31'b0, busy}, 32'd1);
    n = 0;
    while (busy) begin n++; tick(); end
    chk("R4 busy length", n, WR_TICKS);
    read_chk("R7 written byte", 15'h105, 8'hA5);
    read_chk("R7 neighbour below", 15'h104, 8'hFF);
    read_chk("R7 neighbour above", 15'h106, 8'hFF);
    read_chk("R10 address wraps", 15'h105 + 3 * MEM_BYTES, 8'hA5);

    // 68-byte burst, later bytes carry another row
    pulse_start();
    for (int i = 0; i < 68; i++)
      put_byte((i == 0) ? (2 << 6) : ((9 << 6) | (i % 64)), 8'h10 + i);
    pulse_stop();
    wait_idle();
    read_chk("R8 col0 last wins", (2 << 6) | 0, 8'h50);
    read_chk("R8 col3 last wins", (2 << 6) | 3, 8'h53);
    read_chk("R8 col4 single", (2 << 6) | 4, 8'h14);
    read_chk("R8 col63", (2 << 6) | 63, 8'h4F);
    read_chk("R2 later row ignored", (9 << 6) | 5, 8'hFF);

    // write protect
    wprot = 1;
    pulse_start();
    put_byte(15'h300, 8'h11);
    pulse_stop();
    chk("R6 no busy when protected", {31'b0, busy}, 32'd0);
    wprot = 0;
    pulse_stop();
    chk("R6 buffer dropped", {31'b0, busy}, 32'd0);
    read_chk("R6 array unchanged", 15'h300, 8'hFF);

    // restart and abort discard
    pulse_start();
    put_byte(15'h310, 8'h22);
    pulse_start();
    pulse_stop();
    chk("R9 restart discards", {31'b0, busy}, 32'd0);
    read_chk("R9 restart byte absent", 15'h310, 8'hFF);
    pulse_start();
    put_byte(15'h311, 8'h33);
    pulse_abort();
    pulse_stop();
    chk("R9 abort discards", {31'b0, busy}, 32'd0);
    read_chk("R9 abort byte absent", 15'h311, 8'hFF);

    // dummy write: stop with nothing staged
    pulse_start();
    pulse_stop();
    chk("R3 empty stop no cycle", {31'b0, busy}, 32'd0);

    // accesses during busy
    pulse_start();
    put_byte(15'h040, 8'h77);
    pulse_stop();
    wr_valid = 1; wr_addr = 15'h041; wr_data = 8'h88;
    #0.5;
    chk("R5 wr_ready low in busy", {31'b0, wr_ready}, 32'd0);
    tick();
    wr_valid = 0;
    rd_valid = 1; rd_addr = 15'h040;
    tick();
    rd_valid = 0;
    chk("R5 read refused in busy", {31'b0, rd_rsp_valid}, 32'd0);
    pulse_stop();
    pulse_start();
    wait_idle();
    tick();
    chk("R5 busy not retriggered", {31'b0, busy}, 32'd0);
    read_chk("R5 committed byte", 15'h040, 8'h77);
    read_chk("R5 busy-time byte ignored", 15'h041, 8'hFF);
    pulse_stop();
    chk("R3 stop after commit no cycle", {31'b0, busy}, 32'd0);

    // byte offered together with a stop
    pulse_start();
    wr_valid = 1; wr_addr = 15'h050; wr_data = 8'h99; txn_stop = 1;
    #0.5;
    chk("R11 wr_ready low with stop", {31'b0, wr_ready}, 32'd0);
    tick();
    wr_valid = 0; txn_stop = 0;
    chk("R11 no cycle from dropped byte", {31'b0, busy}, 32'd0);
    read_chk("R11 byte not written", 15'h050, 8'hFF);

    repeat (3) tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule